// File: doc/BRIEF.md
# Masked Latched Interrupt Controller

This block gathers twelve one-cycle event sources into a latched status word and drives one level-sensitive interrupt line toward a processor. Eight sources are generic event pulses with no meaning fixed here. Three sources are pulses from a real-time-clock block: a periodic tick, an alarm match and a time-update error. The last source is a push-button level, and only its rising edge counts. A status bit stays set until software clears it. An event that occurs while its source is masked is still latched.

Software reaches the block through a byte-wide register port. The 16-bit status view, the 12-bit mask and the write-one-to-clear acknowledge are each split over a low-byte register and a high-byte register. The interrupt line is registered. It follows status AND NOT mask in the same clock edge that changes either of them.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While `rst` is high, and after its release, status is 0, the mask is 0x0FFF (every source masked) and `irq_out` is low.
- R2: A one-cycle high pulse on a source sets its status bit at the next rising clock edge. The bit positions are: `gen_evt[i]` to bit i (i = 0..7), `tick_evt` to bit 8, `alarm_evt` to bit 9, `uperr_evt` to bit 10 and the push-button to bit 11. Status bits 15..12 always read 0.
- R3: `irq_out` is high exactly when a status bit is set whose mask bit is 0. It is updated at the same edge that changes status or mask, including an edge caused by an acknowledge or mask write.
- R4: The push-button sets bit 11 only when `btn_in` goes from low to high. Holding `btn_in` high does not set the bit again after it has been acknowledged.
- R5: A write to address 0x1B clears every status bit in [7:0] whose written data bit is 1. A write to 0x1C does the same for [15:8]. Bits written as 0 keep their value.
- R6: A write to 0x17 replaces mask[7:0]. A write to 0x18 replaces mask[11:8] with `wdata[3:0]`. Neither write touches the other byte. Reading 0x18 returns 0 in bits 7..4.
- R7: Read map: 0x17 gives mask low, 0x18 gives mask high, 0x19 gives status[7:0], 0x1A gives status[15:8]. The acknowledge addresses 0x1B and 0x1C, and every other address, read 0. `rdata` is loaded at the clock edge where `rd_en` is high and holds its value until the next read.
- R8: When an event and an acknowledge of the same bit fall in the same cycle, the event wins and the bit stays set.
- R9: Writes to the status addresses 0x19 and 0x1A have no effect.
- R10: A masked source still latches its status bit. Clearing its mask bit later raises `irq_out` without a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| gen_evt | input | 8 | Generic event pulses, status bits 7..0 |
| tick_evt | input | 1 | Clock periodic tick pulse |
| alarm_evt | input | 1 | Clock alarm pulse |
| uperr_evt | input | 1 | Clock update error pulse |
| btn_in | input | 1 | Push-button level |
| irq_out | output | 1 | Level interrupt request |

## Verification
Two situations are hardest to reach from the ports. The first is a race between an event and a software acknowledge of the same bit. The second is a push-button that stays high through an acknowledge. For the race, a bench task raises the event pulse in the same cycle as the acknowledge write, and then reads the bit back to show that it is still set. For the button, the bench holds `btn_in` high across the acknowledge and several further cycles, reads status back, and then releases and presses the button again to show that a new edge is still recognised.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned VIEW_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] reg_addr_t;

  localparam reg_addr_t RA_MASK_LO = 8'h17;
  localparam reg_addr_t RA_MASK_HI = 8'h18;
  localparam reg_addr_t RA_STAT_LO = 8'h19;
  localparam reg_addr_t RA_STAT_HI = 8'h1A;
  localparam reg_addr_t RA_ACK_LO  = 8'h1B;
  localparam reg_addr_t RA_ACK_HI  = 8'h1C;
endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] stat_nxt_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic bit_q;
    // a new event takes priority over a clear in the same cycle
    always_comb begin
      if (set_i[b])      stat_nxt_o[b] = 1'b1;
      else if (clr_i[b]) stat_nxt_o[b] = 1'b0;
      else               stat_nxt_o[b] = bit_q;
    end
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= stat_nxt_o[b];
    end
    assign stat_o[b] = bit_q;
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_latch_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_addr_t         addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [N-1:0]      stat_i,
  output logic [BYTE_W-1:0] rdata,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      mask_nxt_o
);
  logic [N-1:0]      mask_q;
  logic [VIEW_W-1:0] mask_view, stat_view, mask_wide, clr_wide;
  logic [BYTE_W-1:0] rd_nxt;

  assign mask_view = VIEW_W'(mask_q);
  assign stat_view = VIEW_W'(stat_i);

  always_comb begin
    mask_wide = mask_view;
    clr_wide  = '0;
    if (wr_en) begin
      case (addr)
        RA_MASK_LO: mask_wide[BYTE_W-1:0]      = wdata;
        RA_MASK_HI: mask_wide[VIEW_W-1:BYTE_W] = wdata;
        RA_ACK_LO:  clr_wide[BYTE_W-1:0]       = wdata;
        RA_ACK_HI:  clr_wide[VIEW_W-1:BYTE_W]  = wdata;
        default:    ;
      endcase
    end
  end

  assign mask_nxt_o = mask_wide[N-1:0];
  assign clr_o      = clr_wide[N-1:0];
  assign mask_o     = mask_q;

  always_comb begin
    case (addr)
      RA_MASK_LO: rd_nxt = mask_view[BYTE_W-1:0];
      RA_MASK_HI: rd_nxt = mask_view[VIEW_W-1:BYTE_W];
      RA_STAT_LO: rd_nxt = stat_view[BYTE_W-1:0];
      RA_STAT_HI: rd_nxt = stat_view[VIEW_W-1:BYTE_W];
      default:    rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      rdata  <= '0;
    end else begin
      mask_q <= mask_nxt_o;
      if (rd_en) rdata <= rd_nxt;
    end
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int unsigned GEN_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [GEN_N-1:0] gen_evt,
  input  logic             tick_evt,
  input  logic             alarm_evt,
  input  logic             uperr_evt,
  input  logic             btn_in,
  output logic             irq_out
);
  localparam int unsigned NSRC = GEN_N + 4;

  logic            btn_rise;
  logic [NSRC-1:0] src_vec, clr_vec, stat_q, stat_nxt, mask_q, mask_nxt;

  irq_rise_detect #(.W(1)) u_btn (
    .clk(clk), .rst(rst), .lvl_i(btn_in), .rise_o(btn_rise)
  );

  assign src_vec = {btn_rise, uperr_evt, alarm_evt, tick_evt, gen_evt};

  irq_status_bank #(.N(NSRC)) u_stat (
    .clk(clk), .rst(rst), .set_i(src_vec), .clr_i(clr_vec),
    .stat_o(stat_q), .stat_nxt_o(stat_nxt)
  );

  irq_reg_port #(.N(NSRC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .stat_i(stat_q), .rdata(rdata), .clr_o(clr_vec),
    .mask_o(mask_q), .mask_nxt_o(mask_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(stat_nxt & ~mask_nxt);
  end
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
  import irq_latch_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [7:0]   addr,
  input logic [7:0]   wdata,
  input logic         btn_in,
  input logic         irq_out,
  input logic [N-1:0] stat,
  input logic [N-1:0] mask,
  input logic [N-1:0] src
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!irq_out && stat == '0 && mask == '1));

  a_r3_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(stat & ~mask));

  a_r8_event_latches: assert property (@(posedge clk) disable iff (rst)
    (src != '0) |=> ((stat & $past(src)) == $past(src)));

  a_r5_ack_lo_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == RA_ACK_LO && src == '0) |=> ((stat[7:0] & $past(wdata)) == 8'h00));

  a_r9_status_ro: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == RA_STAT_LO || addr == RA_STAT_HI) && src == '0) |=> $stable(stat));

  a_r4_btn_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[N-1]) |-> $past(btn_in));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.N(NSRC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .btn_in(btn_in), .irq_out(irq_out), .stat(stat_q), .mask(mask_q), .src(src_vec)
);

// File: tb/sim_irq_latch_ctrl.sv
`timescale 1ns/1ps
module sim_irq_latch_ctrl;
  import irq_latch_pkg::*;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [7:0] gen_evt = '0;
  logic tick_evt = 1'b0, alarm_evt = 1'b0, uperr_evt = 1'b0, btn_in = 1'b0;
  logic irq_out;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_latch_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gen_evt(gen_evt), .tick_evt(tick_evt),
    .alarm_evt(alarm_evt), .uperr_evt(uperr_evt), .btn_in(btn_in),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] g, input logic t, input logic al, input logic ue);
    @(negedge clk); gen_evt = g; tick_evt = t; alarm_evt = al; uperr_evt = ue;
    @(negedge clk); gen_evt = '0; tick_evt = 0; alarm_evt = 0; uperr_evt = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    rd(RA_STAT_LO, d); chk("R1 status lo", d, 8'h00);
    rd(RA_STAT_HI, d); chk("R1 status hi", d, 8'h00);
    rd(RA_MASK_LO, d); chk("R1 R7 mask lo", d, 8'hFF);
    rd(RA_MASK_HI, d); chk("R1 R6 mask hi", d, 8'h0F);
  endtask

  task automatic t_generic();
    logic [7:0] d;
    pulse(8'h08, 0, 0, 0);
    rd(RA_STAT_LO, d); chk("R2 gen bit3", d, 8'h08);
    chk("R10 masked no irq", {7'd0, irq_out}, 8'h00);
    wr(RA_MASK_LO, 8'hF7);
    chk("R10 R3 irq on unmask", {7'd0, irq_out}, 8'h01);
    pulse(8'h81, 0, 0, 0);
    rd(RA_STAT_LO, d); chk("R2 gen bits 7,3,0", d, 8'h89);
    wr(RA_ACK_LO, 8'h08);
    chk("R3 irq after ack", {7'd0, irq_out}, 8'h00);
    rd(RA_STAT_LO, d); chk("R5 ack lo partial", d, 8'h81);
    wr(RA_ACK_LO, 8'hFF);
    rd(RA_STAT_LO, d); chk("R5 ack lo all", d, 8'h00);
  endtask

  task automatic t_rtc();
    logic [7:0] d;
    pulse(8'h00, 1, 0, 0);
    rd(RA_STAT_HI, d); chk("R2 tick bit8", d, 8'h01);
    pulse(8'h00, 0, 1, 0);
    pulse(8'h00, 0, 0, 1);
    rd(RA_STAT_HI, d); chk("R2 alarm and error bits", d, 8'h07);
    rd(RA_STAT_LO, d); chk("R2 low byte untouched", d, 8'h00);
    wr(RA_ACK_HI, 8'h02);
    rd(RA_STAT_HI, d); chk("R5 ack hi partial", d, 8'h05);
    wr(RA_MASK_HI, 8'hFB);
    rd(RA_MASK_HI, d); chk("R6 mask hi nibble", d, 8'h0B);
    rd(RA_MASK_LO, d); chk("R6 mask lo kept", d, 8'hF7);
    chk("R3 irq via bit10", {7'd0, irq_out}, 8'h01);
    wr(RA_ACK_HI, 8'hFF);
    chk("R3 irq clear hi", {7'd0, irq_out}, 8'h00);
    rd(RA_STAT_HI, d); chk("R5 ack hi all", d, 8'h00);
  endtask

  task automatic t_button();
    logic [7:0] d;
    wr(RA_MASK_HI, 8'h07);
    @(negedge clk); btn_in = 1'b1;
    @(negedge clk);
    rd(RA_STAT_HI, d); chk("R4 R2 button edge", d, 8'h08);
    chk("R3 button irq", {7'd0, irq_out}, 8'h01);
    wr(RA_ACK_HI, 8'h08);
    repeat (5) @(negedge clk);
    rd(RA_STAT_HI, d); chk("R4 held no reset", d, 8'h00);
    chk("R4 held irq low", {7'd0, irq_out}, 8'h00);
    @(negedge clk); btn_in = 1'b0;
    @(negedge clk); btn_in = 1'b1;
    @(negedge clk); btn_in = 1'b0;
    rd(RA_STAT_HI, d); chk("R4 second press", d, 8'h08);
    wr(RA_ACK_HI, 8'h08);
  endtask

  task automatic t_race();
    logic [7:0] d;
    pulse(8'h03, 0, 0, 0);
    @(negedge clk); wr_en = 1'b1; addr = RA_ACK_LO; wdata = 8'h03; gen_evt = 8'h01;
    @(negedge clk); wr_en = 1'b0; gen_evt = '0;
    rd(RA_STAT_LO, d); chk("R8 event wins over ack", d, 8'h01);
    wr(RA_ACK_LO, 8'h01);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    pulse(8'h10, 0, 0, 0);
    wr(RA_STAT_LO, 8'h00);
    wr(RA_STAT_HI, 8'hFF);
    rd(RA_STAT_LO, d); chk("R9 status lo write ignored", d, 8'h10);
    rd(RA_STAT_HI, d); chk("R9 status hi write ignored", d, 8'h00);
    rd(RA_ACK_LO, d); chk("R7 ack lo reads 0", d, 8'h00);
    rd(RA_ACK_HI, d); chk("R7 ack hi reads 0", d, 8'h00);
    rd(8'h40, d); chk("R7 unmapped reads 0", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_generic();
    t_rtc();
    t_button();
    t_race();
    t_readonly();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule